// File: doc/BRIEF.md
# Dynamic Reconfiguration Port Register Bridge

This block sits on a simple memory-mapped register port and gives software a path to the 16-bit dynamic reconfiguration port of a clock-management tile. Software writes one 32-bit control word that holds a start flag, a direction flag, a 7-bit tile register address and 16 bits of write data. The bridge turns that word into one reconfiguration cycle on the tile side. It then holds a busy flag until the tile answers with ready. A status register shows the busy flag and the result of the most recent tile read.

Two other registers sit next to the bridge. One holds a core-run bit and a tile-enable bit, and both are driven straight out of the block. The other holds the index of the clock source. Software must wait for busy to clear before it writes the next control word. Any control word that arrives while busy is high is dropped.

Top module: `drp_cfg_bridge`

## Requirements
- R1: After the synchronous reset, every register reads zero, and `core_run`, `tile_en`, `src_sel`, `drp_en` and `drp_we` are low.
- R2: The register at offset 0x40 drives `core_run` from bit 0 and `tile_en` from bit 1. It reads back those two bits, and all higher bits read as zero.
- R3: The register at offset 0x44 holds the clock-source index in bit 0 and drives it on `src_sel`. It reads back that bit, all higher bits read as zero, and the index changes only when this register is written.
- R4: A write to offset 0x70 with bit 29 set, made while the bridge is idle, raises `drp_en` for exactly one cycle, starting the cycle after the write. In that cycle `drp_addr` equals bits 22:16 of the word, `drp_di` equals bits 15:0, and `drp_we` is high only when bit 28 is clear.
- R5: Status bit 16 (busy), at offset 0x74, goes high with the accepted control write. It stays high until `drp_rdy` is sampled high in a cycle after the enable pulse, and it reads low from the next cycle on.
- R6: When a read cycle completes (bit 28 was set), status bits 15:0 take the value of `drp_do` in the cycle where `drp_rdy` is high. When a write cycle completes, bits 15:0 keep their old value.
- R7: A control write made while busy is high is ignored. It produces no enable pulse and does not change the control readback.
- R8: The control register reads back bits 29, 28, 22:16 and 15:0 of the last accepted word, and every other bit reads as zero. A word with bit 29 clear is stored but starts no cycle.
- R9: Reads from any offset other than 0x40, 0x44, 0x70 and 0x74 return zero. Writes to those offsets change no register.
- R10: `bus_rdata` is registered. It shows the addressed register in the cycle after `bus_rd` is sampled.
- R11: A `drp_rdy` pulse that arrives while the bridge is idle changes neither busy nor the status data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | REG_AW (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| core_run | output | 1 | Core-run control bit |
| tile_en | output | 1 | Clock-tile enable bit |
| src_sel | output | SEL_W (1) | Clock-source index |
| drp_en | output | 1 | One-cycle reconfiguration enable |
| drp_we | output | 1 | Write enable, qualified by `drp_en` |
| drp_addr | output | DRP_AW (7) | Tile register address |
| drp_di | output | DRP_DW (16) | Data to the tile |
| drp_do | input | DRP_DW (16) | Data from the tile |
| drp_rdy | input | 1 | Tile ready |

## Verification
The bench uses the default parameters: a 7-bit tile address, 16-bit tile data and a single select bit. With a 7-bit address the bench can sweep every tile register with a write followed by a read. The responder latency runs from one to five cycles across the sweep, so busy is seen at each length of wait. The two small configuration registers are walked through every value. Every unmapped word offset of the 8-bit register space is read and written. The remaining cases are covered one by one: a control write made while busy, a control word with the start bit clear, and a stray ready while idle.

// File: rtl/drp_cfg_bridge_pkg.sv
package drp_cfg_bridge_pkg;
  // Register byte offsets
  localparam int OFS_RUN    = 'h40;
  localparam int OFS_SEL    = 'h44;
  localparam int OFS_CTL    = 'h70;
  localparam int OFS_STAT   = 'h74;
  // Control word layout
  localparam int GO_BIT     = 29;
  localparam int RD_BIT     = 28;
  localparam int ADDR_LSB   = 16;
  // Status word layout
  localparam int BUSY_BIT   = 16;
  // Run/enable register layout
  localparam int RUN_BIT    = 0;
  localparam int TEN_BIT    = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RUN,
    SEL_SRC,
    SEL_CTL,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/drp_cfg_ctl_regs.sv
module drp_cfg_ctl_regs #(
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_we,
  input  logic [1:0]       run_wdata,
  input  logic             src_we,
  input  logic [SEL_W-1:0] src_wdata,
  output logic             core_run,
  output logic             tile_en,
  output logic [SEL_W-1:0] src_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      core_run <= 1'b0;
      tile_en  <= 1'b0;
      src_sel  <= '0;
    end else begin
      if (run_we) begin
        core_run <= run_wdata[0];
        tile_en  <= run_wdata[1];
      end
      if (src_we) begin
        src_sel <= src_wdata;
      end
    end
  end

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !src_we |=> $stable(src_sel)); // R3
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run_we |=> ($stable(core_run) && $stable(tile_en))); // R2
endmodule

// File: rtl/drp_cfg_sequencer.sv
module drp_cfg_sequencer #(
  parameter int DRP_AW = 7,
  parameter int DRP_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_go,
  input  logic              ctl_rd,
  input  logic [DRP_AW-1:0] ctl_addr,
  input  logic [DRP_DW-1:0] ctl_data,
  output logic              busy,
  output logic              sh_go,
  output logic              sh_rd,
  output logic [DRP_DW-1:0] rd_data,
  output logic              drp_en,
  output logic              drp_we,
  output logic [DRP_AW-1:0] drp_addr,
  output logic [DRP_DW-1:0] drp_di,
  input  logic [DRP_DW-1:0] drp_do,
  input  logic              drp_rdy
);
  logic accept;
  logic finish;
  logic op_rd;

  assign accept = ctl_we && !busy;
  assign finish = busy && !drp_en && drp_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sh_go    <= 1'b0;
      sh_rd    <= 1'b0;
      op_rd    <= 1'b0;
      rd_data  <= '0;
      drp_en   <= 1'b0;
      drp_we   <= 1'b0;
      drp_addr <= '0;
      drp_di   <= '0;
    end else begin
      drp_en <= 1'b0;
      drp_we <= 1'b0;
      if (accept) begin
        sh_go    <= ctl_go;
        sh_rd    <= ctl_rd;
        drp_addr <= ctl_addr;
        drp_di   <= ctl_data;
        if (ctl_go) begin
          busy   <= 1'b1;
          drp_en <= 1'b1;
          drp_we <= !ctl_rd;
          op_rd  <= ctl_rd;
        end
      end
      if (finish) begin
        busy <= 1'b0;
        if (op_rd) begin
          rd_data <= drp_do;
        end
      end
    end
  end

  AST_EN_PULSE: assert property (@(posedge clk) disable iff (rst)
    drp_en |=> !drp_en); // R4
  AST_WE_QUAL: assert property (@(posedge clk) disable iff (rst)
    drp_we |-> drp_en); // R4
  AST_EN_BUSY: assert property (@(posedge clk) disable iff (rst)
    drp_en |-> busy); // R5
  AST_RDY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (busy && !drp_en && drp_rdy) |=> !busy); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && !drp_en && !drp_rdy) |=> (busy && !drp_en)); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !drp_rdy |=> $stable(rd_data)); // R6
  AST_IDLE_RDY: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ctl_we) |=> (!busy && $stable(rd_data))); // R11
endmodule

// File: rtl/drp_cfg_readback.sv
module drp_cfg_readback
  import drp_cfg_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DRP_AW = 7,
  parameter int DRP_DW = 16,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  reg_sel_e          rd_sel,
  input  logic              core_run,
  input  logic              tile_en,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              busy,
  input  logic              sh_go,
  input  logic              sh_rd,
  input  logic [DRP_AW-1:0] sh_addr,
  input  logic [DRP_DW-1:0] sh_data,
  input  logic [DRP_DW-1:0] rd_data,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] run_word, src_word, ctl_word, stat_word, next_word;

  always_comb begin
    run_word            = '0;
    run_word[RUN_BIT]   = core_run;
    run_word[TEN_BIT]   = tile_en;
    src_word            = '0;
    src_word[SEL_W-1:0] = src_sel;
    ctl_word                       = '0;
    ctl_word[GO_BIT]               = sh_go;
    ctl_word[RD_BIT]               = sh_rd;
    ctl_word[ADDR_LSB +: DRP_AW]   = sh_addr;
    ctl_word[DRP_DW-1:0]           = sh_data;
    stat_word                      = '0;
    stat_word[BUSY_BIT]            = busy;
    stat_word[DRP_DW-1:0]          = rd_data;
    unique case (rd_sel)
      SEL_RUN:  next_word = run_word;
      SEL_SRC:  next_word = src_word;
      SEL_CTL:  next_word = ctl_word;
      SEL_STAT: next_word = stat_word;
      default:  next_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= next_word;
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == SEL_NONE) |=> (rdata == '0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R10
endmodule

// File: rtl/drp_cfg_bridge.sv
module drp_cfg_bridge
  import drp_cfg_bridge_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int DATA_W = 32,
  parameter int DRP_AW = 7,
  parameter int DRP_DW = 16,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_run,
  output logic              tile_en,
  output logic [SEL_W-1:0]  src_sel,
  output logic              drp_en,
  output logic              drp_we,
  output logic [DRP_AW-1:0] drp_addr,
  output logic [DRP_DW-1:0] drp_di,
  input  logic [DRP_DW-1:0] drp_do,
  input  logic              drp_rdy
);
  reg_sel_e          dec;
  logic              busy, sh_go, sh_rd;
  logic [DRP_DW-1:0] rd_data;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata;

  always_comb begin
    if      (bus_addr == REG_AW'(OFS_RUN))  dec = SEL_RUN;
    else if (bus_addr == REG_AW'(OFS_SEL))  dec = SEL_SRC;
    else if (bus_addr == REG_AW'(OFS_CTL))  dec = SEL_CTL;
    else if (bus_addr == REG_AW'(OFS_STAT)) dec = SEL_STAT;
    else                                    dec = SEL_NONE;
  end

  drp_cfg_ctl_regs #(.SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .run_we    (bus_wr && dec == SEL_RUN),
    .run_wdata ({bus_wdata[TEN_BIT], bus_wdata[RUN_BIT]}),
    .src_we    (bus_wr && dec == SEL_SRC),
    .src_wdata (bus_wdata[SEL_W-1:0]),
    .core_run  (core_run),
    .tile_en   (tile_en),
    .src_sel   (src_sel)
  );

  drp_cfg_sequencer #(.DRP_AW(DRP_AW), .DRP_DW(DRP_DW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .ctl_we   (bus_wr && dec == SEL_CTL),
    .ctl_go   (bus_wdata[GO_BIT]),
    .ctl_rd   (bus_wdata[RD_BIT]),
    .ctl_addr (bus_wdata[ADDR_LSB +: DRP_AW]),
    .ctl_data (bus_wdata[DRP_DW-1:0]),
    .busy     (busy),
    .sh_go    (sh_go),
    .sh_rd    (sh_rd),
    .rd_data  (rd_data),
    .drp_en   (drp_en),
    .drp_we   (drp_we),
    .drp_addr (drp_addr),
    .drp_di   (drp_di),
    .drp_do   (drp_do),
    .drp_rdy  (drp_rdy)
  );

  drp_cfg_readback #(
    .DATA_W(DATA_W), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW), .SEL_W(SEL_W)
  ) u_rb (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_rd),
    .rd_sel   (dec),
    .core_run (core_run),
    .tile_en  (tile_en),
    .src_sel  (src_sel),
    .busy     (busy),
    .sh_go    (sh_go),
    .sh_rd    (sh_rd),
    .sh_addr  (drp_addr),
    .sh_data  (drp_di),
    .rd_data  (rd_data),
    .rdata    (bus_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!drp_en && !core_run && !tile_en && bus_rdata == '0)); // R1
endmodule

// File: tb/drp_cfg_bridge_tb_top.sv
module drp_cfg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_run, tile_en;
  logic [0:0]  src_sel;
  logic        drp_en, drp_we;
  logic [6:0]  drp_addr;
  logic [15:0] drp_di;
  logic [15:0] drp_do = 16'hDEAD;
  logic        drp_rdy = 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int lat = 1, pulses = 0;
  bit inject = 0;
  logic [15:0] mem [128];
  bit pend = 0;
  int cnt = 0;
  logic [6:0] cap_a;

  always #4 clk = ~clk;

  drp_cfg_bridge dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_run(core_run),
    .tile_en(tile_en), .src_sel(src_sel), .drp_en(drp_en), .drp_we(drp_we),
    .drp_addr(drp_addr), .drp_di(drp_di), .drp_do(drp_do), .drp_rdy(drp_rdy)
  );

  // Behavioural tile responder with variable ready latency
  always @(negedge clk) begin
    drp_rdy = 1'b0;
    drp_do  = 16'hDEAD;
    if (drp_en) begin
      pulses++;
      pend  = 1;
      cnt   = lat;
      cap_a = drp_addr;
      if (drp_we) mem[drp_addr] = drp_di;
    end else if (pend) begin
      if (cnt <= 1) begin
        drp_rdy = 1'b1;
        drp_do  = mem[cap_a];
        pend    = 0;
      end else cnt--;
    end else if (inject) begin
      drp_rdy = 1'b1;
      drp_do  = 16'hBEEF;
      inject  = 0;
    end
  end

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      report();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] s;
    bit done = 0;
    for (int i = 0; i < 40 && !done; i++) begin
      rd(8'h74, s);
      if (!s[16]) done = 1;
    end
    chk(req, {31'b0, done}, 32'd1);
  endtask

  function automatic logic [15:0] pat(int a, int p);
    return 16'((a * 16'h0131 + p * 16'h2F1B) ^ 16'h5A5A);
  endfunction

  initial begin
    logic [31:0] v;
    logic [15:0] last;
    int p0;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 outs", {27'b0, core_run, tile_en, src_sel, drp_en, drp_we}, 32'd0);
    rd(8'h40, v); chk("R1 run", v, 0);
    rd(8'h44, v); chk("R1 sel", v, 0);
    rd(8'h70, v); chk("R1 ctl", v, 0);
    rd(8'h74, v); chk("R1 stat", v, 0);
    // R2 / R3 / R10 sweeps with upper bits set
    for (int r = 0; r < 4; r++) begin
      wr(8'h40, 32'hFFFF_FFFC | r);
      chk("R2 pins", {30'b0, tile_en, core_run}, r);
      rd(8'h40, v); chk("R2 R10 readback", v, r);
    end
    for (int s = 0; s < 2; s++) begin
      wr(8'h44, 32'hFFFF_FFFE | s);
      chk("R3 pin", {31'b0, src_sel}, s);
      wr(8'h40, 32'd0);
      chk("R3 held", {31'b0, src_sel}, s);
      rd(8'h44, v); chk("R3 readback", v, s);
    end
    wr(8'h40, 32'd2);
    // R9 unmapped offsets
    for (int o = 0; o < 256; o += 4) begin
      if (o == 'h40 || o == 'h44 || o == 'h70 || o == 'h74) continue;
      wr(8'(o), 32'hFFFF_FFFF);
      rd(8'(o), v); chk("R9 unmapped read", v, 0);
    end
    rd(8'h40, v); chk("R9 run untouched", v, 2);
    rd(8'h44, v); chk("R9 sel untouched", v, 1);
    chk("R9 no pulse", pulses, 0);
    // R8 start bit clear
    wr(8'h70, 32'hDFFF_FFFF);
    chk("R8 no enable", {31'b0, drp_en}, 0);
    rd(8'h70, v); chk("R8 readback mask", v, 32'h107F_FFFF);
    rd(8'h74, v); chk("R8 not busy", v, 0);
    // R11 stray ready when idle
    inject = 1;
    @(negedge clk); @(negedge clk);
    rd(8'h74, v); chk("R11 idle ready ignored", v, 0);
    // R4 R5 R6 full address sweep
    last = '0;
    for (int a = 0; a < 128; a++) begin
      logic [15:0] d = pat(a, 1);
      lat = 1 + (a % 5);
      wr(8'h70, 32'h2000_0000 | (a << 16) | d);
      chk("R4 write pulse", {drp_en, drp_we, 7'(drp_addr), drp_di}, {1'b1, 1'b1, 7'(a), d});
      rd(8'h74, v); chk("R5 busy set", {15'b0, v[16:0]}, {15'b0, 1'b1, last});
      chk("R4 single cycle", {31'b0, drp_en}, 0);
      wait_idle("R5 busy clears");
      rd(8'h74, v); chk("R6 write keeps data", v, {16'b0, last});
      wr(8'h70, 32'h3000_0000 | (a << 16));
      chk("R4 read pulse", {drp_en, drp_we, 7'(drp_addr)}, {1'b1, 1'b0, 7'(a)});
      wait_idle("R5 busy clears read");
      rd(8'h74, v); chk("R6 read data", v, {16'b0, d});
      last = d;
    end
    // R7 write while busy
    lat = 6;
    p0 = pulses;
    wr(8'h70, 32'h2000_0000 | (5 << 16) | 16'h1111);
    wr(8'h70, 32'h3000_0000 | (9 << 16) | 16'h2222);
    chk("R7 no second pulse", {31'b0, drp_en}, 0);
    wait_idle("R7 first completes");
    chk("R7 pulse count", pulses - p0, 1);
    rd(8'h70, v); chk("R7 R8 ctl unchanged", v, 32'h2005_1111);
    lat = 2;
    wr(8'h70, 32'h3005_0000);
    wait_idle("R7 readback idle");
    rd(8'h74, v); chk("R7 first write landed", v, 32'h0000_1111);
    // R1 reset again
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    rd(8'h74, v); chk("R1 stat after reset", v, 0);
    chk("R1 pins after reset", {29'b0, core_run, tile_en, src_sel}, 0);
    report();
  end
endmodule